// File: doc/BRIEF.md
# Multi-Threshold Activation Quantizer

This unit sits right after an integer matrix-multiply stage. It takes signed accumulator words and turns each one into a small unsigned activation code. Each word is compared against a table of integer thresholds, and the code is the number of thresholds the word has reached. Any scaling, bias or normalization that came before is folded offline into the threshold values. The unit therefore needs only integer comparators and a population count, with no multipliers, shifters or rounding.

Accumulator words arrive on a valid/ready stream and codes leave on a second valid/ready stream. A single output register gives one cycle of latency and accepts one word per cycle whenever the consumer keeps up. Thresholds are loaded through an address/data/write-enable port into a staging copy. The comparators use a separate working copy, which is refreshed from staging only in a cycle when no word is accepted. A threshold set therefore never changes in the middle of a burst.

Top module: `mt_act_unit`

## Requirements
- R1: For an output width of B bits (default 3) there are 2^B-1 thresholds. The code is the number of working thresholds t for which the input x satisfies x >= t in signed two's-complement, so it ranges from 0 to 2^B-1. Thresholds are meant to be non-decreasing, but the count definition holds for any order.
- R2: A threshold equal to the input counts as reached, and each of several equal thresholds counts once.
- R3: After synchronous active-low reset, `act_valid` is 0 and every threshold, in both copies, is 0. Before any load, a non-negative input therefore yields 2^B-1 and a negative input yields 0.
- R4: A word accepted on a clock edge (`acc_valid` and `acc_ready` both high) shows up as `act_valid`=1 with its code right after that edge. No code appears without an accepted word.
- R5: `acc_ready` is high whenever the output register is empty or its code is taken in the same cycle. With `act_ready` held high, one word is accepted every cycle.
- R6: While `act_valid` is 1 and `act_ready` is 0, `act_valid` and `act_code` hold their values.
- R7: A write with `thr_we`=1 and `thr_addr` < 2^B-1 stores `thr_data` into staging entry `thr_addr`. Index 0 is the lowest threshold. A write to address 2^B-1 (all ones) is ignored.
- R8: The working set is copied from staging only at the end of a cycle in which no word is accepted. Words accepted before that cycle use the old set.
- R9: Codes leave in the order their words were accepted, one code per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_we | input | 1 | Threshold write enable |
| thr_addr | input | OUT_B | Threshold index |
| thr_data | input | ACC_W | Signed threshold value |
| acc_valid | input | 1 | Accumulator word valid |
| acc_ready | output | 1 | Unit can take a word |
| acc_data | input | ACC_W | Signed accumulator word |
| act_valid | output | 1 | Activation code valid |
| act_ready | input | 1 | Consumer takes the code |
| act_code | output | OUT_B | Activation code |

## Verification
The bench targets inputs one below, equal to and one above each threshold, duplicated thresholds, and the most negative and most positive accumulator values. A design that used a strict comparison would return codes that are too low at equality. A design that compared unsigned would map negative words to high codes.

It also loads new thresholds while words stream back to back. A design that swapped sets immediately would quantize the rest of the burst with the new set.

Writes to the all-ones address test that the address is checked: a design that did not check it would corrupt a neighbouring entry. Random stalls on the output catch a code that changes under backpressure, and catch a ready that drops when the register is being emptied.

// File: rtl/mt_act_pkg.sv
package mt_act_pkg;
  localparam int unsigned ACC_W_MIN = 16;
  localparam int unsigned ACC_W_MAX = 32;

  // number of thresholds for an output code width
  function automatic int unsigned thr_count(input int unsigned code_bits);
    return (1 << code_bits) - 1;
  endfunction
endpackage

// File: rtl/mt_thr_bank.sv
module mt_thr_bank #(
  parameter int ACC_W = 24,
  parameter int OUT_B = 3
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [OUT_B-1:0]                           wr_addr,
  input  logic signed [ACC_W-1:0]                    wr_data,
  input  logic                                       hold_i,
  output logic [mt_act_pkg::thr_count(OUT_B)*ACC_W-1:0] thr_flat_o,
  output logic                                       wr_hit_o,
  output logic                                       swap_o
);
  localparam int NTH = mt_act_pkg::thr_count(OUT_B);

  logic pending_q;

  assign wr_hit_o = wr_en && ({1'b0, wr_addr} < (OUT_B+1)'(NTH));
  assign swap_o   = pending_q && !hold_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= wr_hit_o || (pending_q && hold_i);
  end

  for (genvar g = 0; g < NTH; g++) begin : g_entry
    logic signed [ACC_W-1:0] shadow_q;
    logic signed [ACC_W-1:0] active_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_hit_o && (wr_addr == OUT_B'(g))) shadow_q <= wr_data;
        if (swap_o) active_q <= shadow_q;
      end
    end

    assign thr_flat_o[g*ACC_W +: ACC_W] = active_q;
  end
endmodule

// File: rtl/mt_thr_compare.sv
module mt_thr_compare #(
  parameter int ACC_W = 24,
  parameter int OUT_B = 3
) (
  input  logic signed [ACC_W-1:0]                    value_i,
  input  logic [mt_act_pkg::thr_count(OUT_B)*ACC_W-1:0] thr_flat_i,
  output logic [mt_act_pkg::thr_count(OUT_B)-1:0]    hits_o,
  output logic [OUT_B-1:0]                           code_o
);
  localparam int NTH = mt_act_pkg::thr_count(OUT_B);

  function automatic logic reached(input logic signed [ACC_W-1:0] v,
                                   input logic signed [ACC_W-1:0] t);
    return (v >= t);
  endfunction

  function automatic logic [OUT_B-1:0] tally(input logic [NTH-1:0] h);
    logic [OUT_B-1:0] n;
    n = '0;
    for (int i = 0; i < NTH; i++) n = n + OUT_B'(h[i]);
    return n;
  endfunction

  for (genvar g = 0; g < NTH; g++) begin : g_cmp
    assign hits_o[g] = reached(value_i, $signed(thr_flat_i[g*ACC_W +: ACC_W]));
  end

  assign code_o = tally(hits_o);
endmodule

// File: rtl/mt_out_stage.sv
module mt_out_stage #(
  parameter int OUT_B = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OUT_B-1:0] code_i,
  output logic             in_ready,
  output logic             fire_o,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_B-1:0] out_code
);
  logic             valid_q;
  logic [OUT_B-1:0] code_q;

  assign in_ready  = !valid_q || out_ready;
  assign fire_o    = in_valid && in_ready;
  assign out_valid = valid_q;
  assign out_code  = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (fire_o) begin
      valid_q <= 1'b1;
      code_q  <= code_i;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mt_act_unit.sv
module mt_act_unit #(
  parameter int ACC_W = 24,
  parameter int OUT_B = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    thr_we,
  input  logic [OUT_B-1:0]        thr_addr,
  input  logic signed [ACC_W-1:0] thr_data,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic signed [ACC_W-1:0] acc_data,
  output logic                    act_valid,
  input  logic                    act_ready,
  output logic [OUT_B-1:0]        act_code
);
  localparam int NTH = mt_act_pkg::thr_count(OUT_B);

  if (ACC_W < int'(mt_act_pkg::ACC_W_MIN) || ACC_W > int'(mt_act_pkg::ACC_W_MAX)) begin : g_bad_width
    $error("accumulator width out of supported range");
  end

  logic [NTH*ACC_W-1:0] thr_flat;
  logic [NTH-1:0]       cmp_hits;
  logic [OUT_B-1:0]     code_next;
  logic                 acc_fire;
  logic                 thr_wr_hit;
  logic                 swap_evt;

  mt_thr_bank #(.ACC_W(ACC_W), .OUT_B(OUT_B)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (thr_we),
    .wr_addr    (thr_addr),
    .wr_data    (thr_data),
    .hold_i     (acc_fire),
    .thr_flat_o (thr_flat),
    .wr_hit_o   (thr_wr_hit),
    .swap_o     (swap_evt)
  );

  mt_thr_compare #(.ACC_W(ACC_W), .OUT_B(OUT_B)) u_cmp (
    .value_i    (acc_data),
    .thr_flat_i (thr_flat),
    .hits_o     (cmp_hits),
    .code_o     (code_next)
  );

  mt_out_stage #(.OUT_B(OUT_B)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (acc_valid),
    .code_i    (code_next),
    .in_ready  (acc_ready),
    .fire_o    (acc_fire),
    .out_valid (act_valid),
    .out_ready (act_ready),
    .out_code  (act_code)
  );
endmodule

// File: rtl/mt_act_chk.sv
module mt_act_chk #(
  parameter int OUT_B = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_fire,
  input logic             act_valid,
  input logic             act_ready,
  input logic [OUT_B-1:0] act_code,
  input logic [OUT_B-1:0] code_next,
  input logic             swap_evt
);
  // R4
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (act_valid && act_code == $past(code_next)));

  // R4
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && !acc_fire) |=> !act_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |=> (act_valid && $stable(act_code)));

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_ready && !acc_fire) |=> !act_valid);

  // R8
  swap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> !acc_fire);
endmodule

bind mt_act_unit mt_act_chk #(.OUT_B(OUT_B)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .act_valid (act_valid),
  .act_ready (act_ready),
  .act_code  (act_code),
  .code_next (code_next),
  .swap_evt  (swap_evt)
);

// File: tb/tb_mt_act_unit.sv
module tb_mt_act_unit;
  localparam int ACC_W = 24;
  localparam int OUT_B = 3;
  localparam int NTH   = (1 << OUT_B) - 1;
  localparam logic signed [ACC_W-1:0] VMIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] VMAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    thr_we = 1'b0;
  logic [OUT_B-1:0]        thr_addr = '0;
  logic signed [ACC_W-1:0] thr_data = '0;
  logic                    acc_valid = 1'b0;
  logic                    acc_ready;
  logic signed [ACC_W-1:0] acc_data = '0;
  logic                    act_valid;
  logic                    act_ready = 1'b1;
  logic [OUT_B-1:0]        act_code;

  always #2 clk = ~clk;

  mt_act_unit #(.ACC_W(ACC_W), .OUT_B(OUT_B)) dut (.*);

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic signed [ACC_W-1:0] m_shadow [NTH];
  logic signed [ACC_W-1:0] m_active [NTH];
  int exp_q [$];
  bit prev_fire = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, cur_req, act, exp);
    end
  endtask

  function automatic int model_code(input logic signed [ACC_W-1:0] x);
    int n = 0;
    for (int i = 0; i < NTH; i++) if (x >= m_active[i]) n++;
    return n;
  endfunction

  function automatic logic signed [ACC_W-1:0] rnd_val();
    case ($urandom % 8)
      0: return VMIN;
      1: return VMAX;
      default: return ACC_W'($signed($urandom % 256) - 128);
    endcase
  endfunction

  // one cycle: check current outputs, drive new inputs, advance the model
  task automatic step(input bit v, input logic signed [ACC_W-1:0] d, input bit rdy,
                      input bit we, input logic [OUT_B-1:0] a,
                      input logic signed [ACC_W-1:0] td);
    bit fire;
    bit take;
    @(negedge clk);
    // R4 code present exactly when one is owed; R9 order
    chk(act_valid == (exp_q.size() != 0), "R4", int'(act_valid), int'(exp_q.size() != 0));
    if (prev_fire) chk(act_valid == 1'b1, "R4", int'(act_valid), 1);
    if (act_valid && exp_q.size() != 0)
      chk(int'(act_code) == exp_q[0], "R1", int'(act_code), exp_q[0]);
    acc_valid = v; acc_data = d; act_ready = rdy;
    thr_we = we; thr_addr = a; thr_data = td;
    #1;
    // R5
    if (!act_valid || act_ready) chk(acc_ready == 1'b1, "R5", int'(acc_ready), 1);
    fire = acc_valid && acc_ready;
    take = act_valid && act_ready;
    if (take && exp_q.size() != 0) void'(exp_q.pop_front());
    if (fire) exp_q.push_back(model_code(d));
    if (!fire) for (int i = 0; i < NTH; i++) m_active[i] = m_shadow[i];
    if (we && int'(a) < NTH) m_shadow[a] = td;
    prev_fire = fire;
  endtask

  task automatic feed(input logic signed [ACC_W-1:0] d);
    step(1'b1, d, 1'b1, 1'b0, '0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, 1'b0, '0, '0);
  endtask

  task automatic wr(input logic [OUT_B-1:0] a, input logic signed [ACC_W-1:0] td);
    step(1'b0, '0, 1'b1, 1'b1, a, td);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NTH; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    cur_req = "R3";
    #1;
    chk(act_valid == 1'b0, "R3", int'(act_valid), 0);
    chk(acc_ready == 1'b1, "R3", int'(acc_ready), 1);
    feed(0); feed(-1); feed(100); feed(VMIN); feed(VMAX);
    idle(2);

    // R7 directed load, with an ignored write to the all-ones address
    cur_req = "R7";
    wr(0, -1000); wr(1, -10); wr(2, 0); wr(3, 0);
    wr(4, 7); wr(5, 500); wr(6, VMAX);
    wr(3'd7, -5);
    idle(2);
    // R2 boundaries and duplicates
    cur_req = "R2";
    feed(-1001); feed(-1000); feed(-11); feed(-10); feed(-1); feed(0);
    feed(6); feed(7); feed(499); feed(500); feed(VMAX - 1); feed(VMAX); feed(VMIN);
    idle(2);

    // R8 writes during a continuous burst do not act until a gap
    cur_req = "R8";
    feed(0);
    for (int i = 0; i < NTH; i++) step(1'b1, ACC_W'(i * 3), 1'b1, 1'b1, OUT_B'(i), ACC_W'(i * 2));
    feed(5); feed(6);
    idle(1);
    feed(0); feed(5); feed(6); feed(12);
    idle(2);

    // R6 random traffic with backpressure and writes
    cur_req = "R6";
    for (int n = 0; n < 4000; n++) begin
      bit v  = ($urandom % 4) != 0;
      bit rd = ($urandom % 3) != 0;
      bit we = ($urandom % 10) == 0;
      step(v, rnd_val(), rd, we, OUT_B'($urandom), rnd_val());
    end
    // R9 drain in order
    cur_req = "R9";
    idle(4);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule